// File: doc/BRIEF.md
# Serial Audio Frame-Sync Pin Multiplexer

This block owns the two frame-sync pads of a serial audio port: a receive-side pad and a transmit-side pad. Mode inputs from the port's control logic decide what each pad carries. With independent clocking the receive pad carries the receivers' frame sync. With shared clocking the transmit pad carries the frame sync for both directions, and the receive pad is reused. It then serves as a serial flag (output or input) or as an enable that brackets active transmit slots for an external line buffer. Either pad can also be handed over to general-purpose I/O, where it is configured on its own as input, output or disconnected.

The block drives both pads' output enables and output values. It brings the pad levels in through a parameterised synchroniser and hands the frame syncs selected for the core to the receive and transmit engines. It also keeps the output-flag and input-flag bits. These two bits change only at a boundary strobe: the frame strobe in normal mode, the slot strobe in network mode. Frame-sync generation, slot timing and data shifting are done elsewhere and arrive here as strobes and levels.

Top module: `fs_pin_mux`

## Requirements
- R1: While rst_n is low, both pad output enables, both pad outputs, gpio_din_o, rx_fs_core_o, tx_fs_core_o and if1_o are 0. After reset the held output-flag bit is 0.
- R2: With gpio_mode_i=1, each pad follows its own 2-bit code: the receive pad uses gpio_cfg_i[1:0] and the transmit pad uses gpio_cfg_i[3:2]. Code 2'b10 is output: enable 1 and pad value from gpio_dout_i (bit 0 receive, bit 1 transmit). Code 2'b01 is input: enable 0, and gpio_din_o carries the synchronised pad level. Codes 2'b00 and 2'b11 are disconnected: enable 0, and the gpio_din_o bit is 0. A gpio_din_o bit is 0 whenever its pad is not a GPIO input. Whenever an output enable is 0, the matching pad output is 0.
- R3: With sync_mode_i=0 and GPIO off, the receive pad is the receive frame sync. With rx_fs_out_i=1 the pad is driven from rx_fs_gen_i and rx_fs_core_o equals rx_fs_gen_i. With rx_fs_out_i=0 the pad is an input and rx_fs_core_o is its synchronised level.
- R4: With GPIO off, tx_fs_out_i=1 drives the transmit pad from tx_fs_gen_i and tx_fs_core_o equals tx_fs_gen_i. With tx_fs_out_i=0 the pad is an input and tx_fs_core_o is its synchronised level. In GPIO mode both core frame syncs are 0.
- R5: With sync_mode_i=1 and GPIO off, rx_fs_core_o equals tx_fs_core_o.
- R6: With sync_mode_i=1, bufen_sel_i=0, rx_fs_out_i=1 and GPIO off, the receive pad is enabled and shows the held output-flag bit.
- R7: The held output-flag bit takes of1_set_i at a clock edge where the selected boundary strobe is high (frame_strobe_i when net_mode_i=0, slot_strobe_i when net_mode_i=1), and holds otherwise.
- R8: With sync_mode_i=1, bufen_sel_i=0, rx_fs_out_i=0 and GPIO off, the receive pad is an input. if1_o takes its synchronised level at a clock edge with the selected boundary strobe. In all other cycles and modes if1_o holds.
- R9: With sync_mode_i=1, bufen_sel_i=1, rx_fs_out_i=1 and GPIO off, the receive pad is enabled and equals tx_slot_active_i.
- R10: With sync_mode_i=1, bufen_sel_i=1, rx_fs_out_i=0 and GPIO off, the receive pad is not driven.
- R11: Each pad level passes through SYNC_STAGES flops (reset to 0) before it reaches gpio_din_o, the core frame syncs or if1_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_mode_i | input | 1 | Hand both pads to general-purpose I/O |
| gpio_cfg_i | input | 4 | Per-pad GPIO code, receive pad in [1:0] |
| gpio_dout_i | input | 2 | GPIO output values, bit 0 receive pad |
| gpio_din_o | output | 2 | GPIO input values, bit 0 receive pad |
| sync_mode_i | input | 1 | 1 = shared clocking of both directions |
| net_mode_i | input | 1 | 1 = flags align to slot strobe, 0 = frame strobe |
| bufen_sel_i | input | 1 | In shared clocking, select buffer-enable role |
| rx_fs_out_i | input | 1 | Receive pad direction select, 1 = output |
| tx_fs_out_i | input | 1 | Transmit pad direction, 1 = output |
| rx_fs_gen_i | input | 1 | Internally generated receive frame sync |
| tx_fs_gen_i | input | 1 | Internally generated transmit frame sync |
| frame_strobe_i | input | 1 | Frame boundary strobe |
| slot_strobe_i | input | 1 | Slot boundary strobe |
| tx_slot_active_i | input | 1 | Transmitter shifting in the current slot |
| of1_set_i | input | 1 | Requested output-flag value |
| if1_o | output | 1 | Captured input-flag bit |
| rx_fs_core_o | output | 1 | Frame sync handed to the receivers |
| tx_fs_core_o | output | 1 | Frame sync handed to the transmitters |
| rx_pad_i | input | 1 | Receive pad level in |
| rx_pad_oe_o | output | 1 | Receive pad output enable |
| rx_pad_o | output | 1 | Receive pad output value |
| tx_pad_i | input | 1 | Transmit pad level in |
| tx_pad_oe_o | output | 1 | Transmit pad output enable |
| tx_pad_o | output | 1 | Transmit pad output value |

## Verification
The bench builds the block with SYNC_STAGES=2, the default. At that depth the two-cycle gap between a pad edge and its use is visible, so a capture of the input flag on a boundary strobe has to take the level from two cycles earlier. A wrong synchroniser depth or a missing stage therefore shows up as a miscompare. The reference model holds its own delay line and flag bits. It sweeps every combination of GPIO, clocking, role and direction selects under both boundary modes, with random strobes and pad levels.

// File: rtl/fs_pin_pkg.sv
package fs_pin_pkg;

   typedef enum logic [2:0] {
      RX_GPIO,
      RX_FS,
      RX_FLAG_OUT,
      RX_FLAG_IN,
      RX_BUFEN,
      RX_OFF
   } rx_role_e;

   localparam int GPIO_CODE_W = 2;
   localparam logic [GPIO_CODE_W-1:0] GPIO_DISC  = 2'b00;
   localparam logic [GPIO_CODE_W-1:0] GPIO_INPUT = 2'b01;
   localparam logic [GPIO_CODE_W-1:0] GPIO_DRIVE = 2'b10;

   function automatic rx_role_e decode_rx_role(input logic gpio, input logic syn,
                                               input logic bufen, input logic rx_out);
      rx_role_e r;
      if (gpio)        r = RX_GPIO;
      else if (!syn)   r = RX_FS;
      else if (!bufen) r = rx_out ? RX_FLAG_OUT : RX_FLAG_IN;
      else             r = rx_out ? RX_BUFEN : RX_OFF;
      return r;
   endfunction

endpackage

// File: rtl/fs_in_sync.sv
module fs_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 0 || STAGES > 8) begin : g_bad_depth
      $error("fs_in_sync: STAGES must lie in 0..8");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= (chain << 1) | STAGES'(d);
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/fs_gpio_cell.sv
module fs_gpio_cell
   import fs_pin_pkg::*;
(
   input  logic [GPIO_CODE_W-1:0] code,
   input  logic                   dout,
   input  logic                   pad_s,
   output logic                   oe,
   output logic                   out,
   output logic                   din
);
   always_comb begin
      oe  = 1'b0;
      out = 1'b0;
      din = 1'b0;
      unique case (code)
         GPIO_DRIVE: begin oe = 1'b1; out = dout; end
         GPIO_INPUT: din = pad_s;
         default:    ;
      endcase
   end
endmodule

// File: rtl/fs_flag_unit.sv
module fs_flag_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic net_mode,
   input  logic frame_stb,
   input  logic slot_stb,
   input  logic of1_set,
   input  logic cap_en,
   input  logic pin_s,
   output logic of1_q,
   output logic if1_q
);
   logic bnd;
   assign bnd = net_mode ? slot_stb : frame_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         of1_q <= 1'b0;
         if1_q <= 1'b0;
      end else begin
         if (bnd)           of1_q <= of1_set;
         if (bnd && cap_en) if1_q <= pin_s;
      end
   end

   // R7: output flag moves only at the selected boundary
   p_of1_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(net_mode ? slot_stb : frame_stb) |=> $stable(of1_q));
   // R8: input flag holds outside a boundary in flag-input role
   p_if1_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap_en && (net_mode ? slot_stb : frame_stb)) |=> $stable(if1_q));
   p_if1_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && (net_mode ? slot_stb : frame_stb)) |=> (if1_q == $past(pin_s)));
endmodule

// File: rtl/fs_pin_mux.sv
module fs_pin_mux
   import fs_pin_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       gpio_mode_i,
   input  logic [3:0] gpio_cfg_i,
   input  logic [1:0] gpio_dout_i,
   output logic [1:0] gpio_din_o,
   input  logic       sync_mode_i,
   input  logic       net_mode_i,
   input  logic       bufen_sel_i,
   input  logic       rx_fs_out_i,
   input  logic       tx_fs_out_i,
   input  logic       rx_fs_gen_i,
   input  logic       tx_fs_gen_i,
   input  logic       frame_strobe_i,
   input  logic       slot_strobe_i,
   input  logic       tx_slot_active_i,
   input  logic       of1_set_i,
   output logic       if1_o,
   output logic       rx_fs_core_o,
   output logic       tx_fs_core_o,
   input  logic       rx_pad_i,
   output logic       rx_pad_oe_o,
   output logic       rx_pad_o,
   input  logic       tx_pad_i,
   output logic       tx_pad_oe_o,
   output logic       tx_pad_o
);
   localparam int NUM_PADS = 2;

   if ($bits(gpio_cfg_i) != NUM_PADS * GPIO_CODE_W) begin : g_bad_cfg
      $error("fs_pin_mux: GPIO code field width mismatch");
   end

   logic [NUM_PADS-1:0] pad_raw, pad_s;
   logic [NUM_PADS-1:0] g_oe, g_out, g_din;
   assign pad_raw = {tx_pad_i, rx_pad_i};

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      fs_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .d(pad_raw[p]), .q(pad_s[p]));
      fs_gpio_cell u_gpio (
         .code (gpio_cfg_i[p*GPIO_CODE_W +: GPIO_CODE_W]),
         .dout (gpio_dout_i[p]),
         .pad_s(pad_s[p]),
         .oe   (g_oe[p]),
         .out  (g_out[p]),
         .din  (g_din[p]));
   end

   rx_role_e role;
   assign role = decode_rx_role(gpio_mode_i, sync_mode_i, bufen_sel_i, rx_fs_out_i);

   logic of1_q, if1_q;
   fs_flag_unit u_flags (
      .clk(clk), .rst_n(rst_n), .net_mode(net_mode_i),
      .frame_stb(frame_strobe_i), .slot_stb(slot_strobe_i),
      .of1_set(of1_set_i), .cap_en(role == RX_FLAG_IN),
      .pin_s(pad_s[0]), .of1_q(of1_q), .if1_q(if1_q));

   logic tx_fs_sel, rx_fs_sel;
   logic rx_oe_n, rx_out_n, tx_oe_n, tx_out_n, rx_core_n, tx_core_n;
   logic [NUM_PADS-1:0] din_n;

   assign tx_fs_sel = tx_fs_out_i ? tx_fs_gen_i : pad_s[1];
   assign rx_fs_sel = rx_fs_out_i ? rx_fs_gen_i : pad_s[0];

   always_comb begin
      rx_oe_n   = 1'b0;
      rx_out_n  = 1'b0;
      din_n     = '0;
      tx_oe_n   = tx_fs_out_i;
      tx_out_n  = tx_fs_out_i & tx_fs_gen_i;
      tx_core_n = tx_fs_sel;
      rx_core_n = sync_mode_i ? tx_fs_sel : rx_fs_sel;
      unique case (role)
         RX_GPIO: begin
            rx_oe_n   = g_oe[0];
            rx_out_n  = g_out[0];
            tx_oe_n   = g_oe[1];
            tx_out_n  = g_out[1];
            din_n     = g_din;
            tx_core_n = 1'b0;
            rx_core_n = 1'b0;
         end
         RX_FS: begin
            rx_oe_n  = rx_fs_out_i;
            rx_out_n = rx_fs_out_i & rx_fs_gen_i;
         end
         RX_FLAG_OUT: begin
            rx_oe_n  = 1'b1;
            rx_out_n = of1_q;
         end
         RX_BUFEN: begin
            rx_oe_n  = 1'b1;
            rx_out_n = tx_slot_active_i;
         end
         default: ;
      endcase
   end

   assign rx_pad_oe_o  = rst_n & rx_oe_n;
   assign rx_pad_o     = rst_n & rx_out_n;
   assign tx_pad_oe_o  = rst_n & tx_oe_n;
   assign tx_pad_o     = rst_n & tx_out_n;
   assign gpio_din_o   = rst_n ? din_n : '0;
   assign rx_fs_core_o = rst_n & rx_core_n;
   assign tx_fs_core_o = rst_n & tx_core_n;
   assign if1_o        = if1_q;

   // R1: quiet pads during reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> !(rx_pad_oe_o | tx_pad_oe_o | rx_pad_o | tx_pad_o | if1_o));
   // R2: an undriven pad shows 0
   p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_pad_oe_o |-> !rx_pad_o) and (!tx_pad_oe_o |-> !tx_pad_o));
   // R5: shared clocking shares one frame sync
   p_shared_fs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode_i && !gpio_mode_i) |-> (rx_fs_core_o == tx_fs_core_o));
   // R6: flag output role drives the held flag
   p_flag_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode_i && !gpio_mode_i && !bufen_sel_i && rx_fs_out_i)
         |-> (rx_pad_oe_o && rx_pad_o == of1_q));
   // R9: buffer enable follows active slots
   p_bufen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode_i && !gpio_mode_i && bufen_sel_i && rx_fs_out_i)
         |-> (rx_pad_oe_o && rx_pad_o == tx_slot_active_i));
   // R10: invalid combination leaves the pad undriven
   p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode_i && !gpio_mode_i && bufen_sel_i && !rx_fs_out_i) |-> !rx_pad_oe_o);
   // R4: transmit pad direction
   p_tx_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !gpio_mode_i |-> (tx_pad_oe_o == tx_fs_out_i));
endmodule

// File: tb/fs_pin_mux_test.sv
module fs_pin_mux_test;
   localparam int S = 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n;
   logic gpio_mode, sync_mode, net_mode, bufen_sel, rx_out, tx_out;
   logic [3:0] gpio_cfg;
   logic [1:0] gpio_dout, gpio_din;
   logic rx_gen, tx_gen, frame_stb, slot_stb, tx_act, of1_set;
   logic if1, rx_core, tx_core, rx_pad, rx_oe, rx_o, tx_pad, tx_oe, tx_o;

   fs_pin_mux #(.SYNC_STAGES(S)) uut (
      .clk(clk), .rst_n(rst_n), .gpio_mode_i(gpio_mode), .gpio_cfg_i(gpio_cfg),
      .gpio_dout_i(gpio_dout), .gpio_din_o(gpio_din), .sync_mode_i(sync_mode),
      .net_mode_i(net_mode), .bufen_sel_i(bufen_sel), .rx_fs_out_i(rx_out),
      .tx_fs_out_i(tx_out), .rx_fs_gen_i(rx_gen), .tx_fs_gen_i(tx_gen),
      .frame_strobe_i(frame_stb), .slot_strobe_i(slot_stb),
      .tx_slot_active_i(tx_act), .of1_set_i(of1_set), .if1_o(if1),
      .rx_fs_core_o(rx_core), .tx_fs_core_o(tx_core), .rx_pad_i(rx_pad),
      .rx_pad_oe_o(rx_oe), .rx_pad_o(rx_o), .tx_pad_i(tx_pad),
      .tx_pad_oe_o(tx_oe), .tx_pad_o(tx_o));

   int vectors = 0;
   int fails = 0;

   // reference model state
   bit rx_dly[S];
   bit tx_dly[S];
   bit m_of1 = 0;
   bit m_if1 = 0;

   always @(posedge clk) begin
      bit bnd;
      bnd = net_mode ? slot_stb : frame_stb;
      if (!rst_n) begin
         for (int i = 0; i < S; i++) begin rx_dly[i] <= 0; tx_dly[i] <= 0; end
         m_of1 <= 0;
         m_if1 <= 0;
      end else begin
         rx_dly[0] <= rx_pad;
         tx_dly[0] <= tx_pad;
         for (int i = 1; i < S; i++) begin
            rx_dly[i] <= rx_dly[i-1];
            tx_dly[i] <= tx_dly[i-1];
         end
         if (bnd) m_of1 <= of1_set;
         if (bnd && !gpio_mode && sync_mode && !bufen_sel && !rx_out)
            m_if1 <= rx_dly[S-1];
      end
   end

   task automatic chk(string req, string what, logic act, logic exp);
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      bit e_rx_oe, e_rx_o, e_tx_oe, e_tx_o, e_rxc, e_txc;
      bit [1:0] e_din;
      string rq, tq;
      bit rs, ts;
      rs = rx_dly[S-1];
      ts = tx_dly[S-1];
      vectors++;
      if (!rst_n) begin
         chk("R1", "rx_oe", rx_oe, 0); chk("R1", "rx_o", rx_o, 0);
         chk("R1", "tx_oe", tx_oe, 0); chk("R1", "tx_o", tx_o, 0);
         chk("R1", "din0", gpio_din[0], 0); chk("R1", "din1", gpio_din[1], 0);
         chk("R1", "rx_core", rx_core, 0); chk("R1", "tx_core", tx_core, 0);
         chk("R1", "if1", if1, 0);
         return;
      end
      e_din = 2'b00; e_rxc = 0; e_txc = 0;
      e_rx_oe = 0; e_rx_o = 0;
      if (gpio_mode) begin
         rq = "R2"; tq = "R2 R11";
         for (int p = 0; p < 2; p++) begin
            bit [1:0] c; bit oe, o;
            c = gpio_cfg[2*p +: 2];
            oe = (c == 2'b10);
            o = oe ? gpio_dout[p] : 1'b0;
            if (c == 2'b01) e_din[p] = (p == 0) ? rs : ts;
            if (p == 0) begin e_rx_oe = oe; e_rx_o = o; end
            else begin e_tx_oe = oe; e_tx_o = o; end
         end
      end else begin
         tq = "R4 R11";
         e_tx_oe = tx_out;
         e_tx_o = tx_out ? tx_gen : 1'b0;
         e_txc = tx_out ? tx_gen : ts;
         if (!sync_mode) begin
            rq = "R3 R11";
            e_rx_oe = rx_out; e_rx_o = rx_out ? rx_gen : 1'b0;
            e_rxc = rx_out ? rx_gen : rs;
         end else begin
            e_rxc = e_txc;
            if (!bufen_sel && rx_out) begin rq = "R6 R7"; e_rx_oe = 1; e_rx_o = m_of1; end
            else if (!bufen_sel) rq = "R8";
            else if (rx_out) begin rq = "R9"; e_rx_oe = 1; e_rx_o = tx_act; end
            else rq = "R10";
         end
      end
      chk(rq, "rx_oe", rx_oe, e_rx_oe);
      chk(rq, "rx_o", rx_o, e_rx_o);
      chk(gpio_mode ? "R2" : "R4", "tx_oe", tx_oe, e_tx_oe);
      chk(gpio_mode ? "R2" : "R4", "tx_o", tx_o, e_tx_o);
      chk("R2 R11", "din0", gpio_din[0], e_din[0]);
      chk("R2 R11", "din1", gpio_din[1], e_din[1]);
      chk(sync_mode && !gpio_mode ? "R5" : "R3 R11", "rx_core", rx_core, e_rxc);
      chk(tq, "tx_core", tx_core, e_txc);
      chk("R8 R11", "if1", if1, m_if1);
   endtask

   task automatic randomize_data();
      rx_pad = 1'($urandom); tx_pad = 1'($urandom);
      rx_gen = 1'($urandom); tx_gen = 1'($urandom);
      frame_stb = ($urandom_range(0, 5) == 0);
      slot_stb = ($urandom_range(0, 2) == 0);
      tx_act = 1'($urandom); of1_set = 1'($urandom);
      gpio_dout = 2'($urandom);
   endtask

   task automatic run(int n, bit g, bit sy, bit bf, bit ro);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         gpio_mode = g; sync_mode = sy; bufen_sel = bf; rx_out = ro;
         if (k % 16 == 0) begin
            net_mode = 1'($urandom);
            tx_out = 1'($urandom);
            gpio_cfg = 4'($urandom);
         end
         randomize_data();
         #5 compare();
      end
   endtask

   initial begin
      #3_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      rst_n = 0;
      gpio_mode = 0; sync_mode = 0; net_mode = 0; bufen_sel = 0;
      rx_out = 0; tx_out = 0; gpio_cfg = 0;
      randomize_data();
      // R1: reset state with random stimulus
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         gpio_mode = 1'($urandom); sync_mode = 1'($urandom);
         rx_out = 1'($urandom); tx_out = 1'($urandom); gpio_cfg = 4'($urandom);
         randomize_data();
         #5 compare();
      end
      @(negedge clk) rst_n = 1;
      // sweep all role combinations, both boundary modes via net_mode changes
      for (int pass = 0; pass < 3; pass++)
         for (int c = 0; c < 16; c++)
            run(200, c[3], c[2], c[1], c[0]);
      // fully random
      for (int k = 0; k < 100; k++)
         run(20, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule